// File: doc/BRIEF.md
# Low-Power Mode Controller

This block manages power for a small 8-bit microcontroller core. It holds an 8-bit power-control register that software writes through the special-function bus. Setting one bit halts the CPU while the peripherals and the oscillator keep running (idle). Setting another bit stops the oscillator and the peripheral clocks as well (power-down). Any enabled interrupt wakes the core from idle. Power-down ends only through a reset.

The block also sequences reset. A free-running divider produces one tick per machine cycle. The external reset pin is synchronised and then qualified over machine-cycle ticks. An internal reset request and a low-voltage alert are the other reset sources, and the low-voltage alert acts only when its enable bit is set. The CPU leaves reset a fixed number of machine cycles after the last reset source goes away. In power-down the divider is frozen. The pin synchroniser keeps sampling, so a reset asserted on the pin restarts the oscillator and the reset is then qualified.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After power-on reset (`rst_n` low), the register reads 0x00, `cpu_rst` is high, and `periph_clk_en` and `osc_en` are high. With the default 12 clocks per machine cycle, `cpu_rst` is still high after 35 clocks following `rst_n` release and low after the 36th clock.
- R2: A write with `sfr_addr` = 0x87 while the core is running stores all 8 bits of `sfr_wdata`, and the value is visible on `sfr_rdata` on the next cycle. Writes to any other address are ignored. Writes made while `cpu_rst` is high are also ignored.
- R3: Writing a value with bit 0 set and bit 1 clear enters idle on the next cycle. In idle, `cpu_halt` is 1, and `periph_clk_en` and `osc_en` stay 1.
- R4: In idle, any set bit of `irq_req` clears bit 0 of the register and drops `cpu_halt` one cycle later. All other register bits keep their value.
- R5: Writing a value with bit 1 set enters power-down on the next cycle. In power-down, `cpu_halt` is 1 and `periph_clk_en` and `osc_en` are 0.
- R6: In power-down, interrupt requests and register writes have no effect: the core stays halted and the register value is unchanged. Only a reset ends power-down.
- R7: When bits 1 and 0 are both written as 1, power-down is entered and bit 0 is stored as 0. For example, 0x03 reads back as 0x02 and 0xFF reads back as 0xFE.
- R8: An external reset (`pin_rst_n` low) takes effect only if the synchronised pin is still low across two consecutive machine-cycle ticks. A low pulse shorter than one machine cycle changes neither `cpu_rst` nor the register.
- R9: In power-down, a low level on `pin_rst_n` raises `osc_en` within 3 clocks, and a pin held low then resets the block.
- R10: Any reset clears the register to 0x00, holds `cpu_rst` high with `cpu_halt` low and the enables high, and keeps `cpu_rst` high until 3 machine-cycle ticks have passed after the last reset source ends. An `int_rst_req` pulse raises `cpu_rst` on the next cycle.
- R11: `lvd_alert` causes a reset when register bit 5 is 1, including in power-down. When bit 5 is 0, `lvd_alert` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sfr_wr_en | input | 1 | Special-function register write strobe |
| sfr_addr | input | 8 | Special-function register address |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Current power-control register value |
| irq_req | input | NUM_IRQ | Enabled interrupt requests |
| pin_rst_n | input | 1 | External reset pin, active low, asynchronous |
| int_rst_req | input | 1 | Internal reset request |
| lvd_alert | input | 1 | Low-voltage detector output |
| cpu_rst | output | 1 | Holds the CPU core in reset |
| cpu_halt | output | 1 | Halts the CPU core (idle or power-down) |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Main oscillator enable |

## Verification
The checker watches these on every cycle:
- power-down always gates the peripheral clock and halts the core, and the oscillator is off only in power-down;
- idle always ends in the cycle after an interrupt, and power-down is never left except into reset;
- the register never holds both mode bits at once;
- during reset the register reads zero and all enables are on;
- the core leaves reset only on a machine-cycle tick.

Some behaviours need the bench's scenarios instead:
- the exact release delay counted in machine cycles;
- the difference between a short pin glitch and a qualified pin reset;
- oscillator restart from the pin while in power-down;
- whether a low-voltage alert resets the block depending on its enable bit.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [1:0] {
        PM_RESET = 2'd0,
        PM_RUN   = 2'd1,
        PM_IDLE  = 2'd2,
        PM_PDOWN = 2'd3
    } pm_state_e;

    // Bit positions inside the power-control register
    localparam int unsigned BIT_IDLE   = 0;
    localparam int unsigned BIT_PDOWN  = 1;
    localparam int unsigned BIT_LVD_EN = 5;

    localparam int unsigned REG_W = 8;

endpackage

// File: rtl/pwr_mcycle_div.sv
module pwr_mcycle_div #(
    parameter int unsigned MC_CLKS = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (MC_CLKS < 2) ? 1 : $clog2(MC_CLKS);
    localparam logic [CW-1:0] LAST = CW'(MC_CLKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/pwr_pin_qual.sv
module pwr_pin_qual #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned QUAL_MC     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_rst_n,
    input  logic tick,
    output logic pin_active,
    output logic ext_rst_valid
);
    localparam int unsigned QW = $clog2(QUAL_MC + 1);
    localparam logic [QW-1:0] QFULL = QW'(QUAL_MC);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [QW-1:0]          qcnt_q;

    // Synchroniser keeps running on the raw clock in every mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_rst_n};
        end
    end

    assign pin_active = !sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qcnt_q <= '0;
        end else if (!pin_active) begin
            qcnt_q <= '0;
        end else if (tick && (qcnt_q != QFULL)) begin
            qcnt_q <= qcnt_q + 1'b1;
        end
    end

    assign ext_rst_valid = (qcnt_q == QFULL);

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_mode_pkg::*;
#(
    parameter int unsigned    RST_MC   = 3,
    parameter logic [7:0]     SFR_ADDR = 8'h87
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rst_any,
    input  logic             any_irq,
    input  logic             pin_active,
    input  logic             wr_en,
    input  logic [7:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] pcon,
    output pm_state_e        state,
    output logic             cpu_rst,
    output logic             cpu_halt,
    output logic             periph_clk_en,
    output logic             osc_en
);
    localparam int unsigned RW = (RST_MC < 2) ? 1 : $clog2(RST_MC);
    localparam logic [RW-1:0] RLAST = RW'(RST_MC - 1);

    pm_state_e        state_q, state_n;
    logic [REG_W-1:0] pcon_q, pcon_n;
    logic [RW-1:0]    rcnt_q, rcnt_n;
    logic             wr_hit;

    assign wr_hit = wr_en && (wr_addr == SFR_ADDR);

    // Next-state and register update
    always_comb begin
        state_n = state_q;
        pcon_n  = pcon_q;
        rcnt_n  = rcnt_q;
        if (rst_any) begin
            state_n = PM_RESET;
            pcon_n  = '0;
            rcnt_n  = '0;
        end else begin
            unique case (state_q)
                PM_RESET: begin
                    if (tick) begin
                        if (rcnt_q == RLAST) begin
                            state_n = PM_RUN;
                            rcnt_n  = '0;
                        end else begin
                            rcnt_n = rcnt_q + 1'b1;
                        end
                    end
                end
                PM_RUN: begin
                    if (wr_hit) begin
                        pcon_n = wr_data;
                        if (wr_data[BIT_PDOWN]) begin
                            pcon_n[BIT_IDLE] = 1'b0;
                            state_n = PM_PDOWN;
                        end else if (wr_data[BIT_IDLE]) begin
                            state_n = PM_IDLE;
                        end
                    end
                end
                PM_IDLE: begin
                    if (any_irq) begin
                        pcon_n[BIT_IDLE] = 1'b0;
                        state_n = PM_RUN;
                    end
                end
                PM_PDOWN: begin
                    state_n = PM_PDOWN;
                end
                default: begin
                    state_n = PM_RESET;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PM_RESET;
            pcon_q  <= '0;
            rcnt_q  <= '0;
        end else begin
            state_q <= state_n;
            pcon_q  <= pcon_n;
            rcnt_q  <= rcnt_n;
        end
    end

    // Outputs
    always_comb begin
        cpu_rst       = 1'b0;
        cpu_halt      = 1'b0;
        periph_clk_en = 1'b1;
        osc_en        = 1'b1;
        unique case (state_q)
            PM_RESET: cpu_rst = 1'b1;
            PM_RUN:   cpu_halt = 1'b0;
            PM_IDLE:  cpu_halt = 1'b1;
            PM_PDOWN: begin
                cpu_halt      = 1'b1;
                periph_clk_en = 1'b0;
                osc_en        = pin_active;
            end
            default:  cpu_rst = 1'b1;
        endcase
    end

    assign pcon  = pcon_q;
    assign state = state_q;

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int unsigned NUM_IRQ  = 8,
    parameter int unsigned MC_CLKS  = 12,
    parameter int unsigned QUAL_MC  = 2,
    parameter int unsigned RST_MC   = 3,
    parameter logic [7:0]  SFR_ADDR = 8'h87
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sfr_wr_en,
    input  logic [7:0]         sfr_addr,
    input  logic [7:0]         sfr_wdata,
    output logic [7:0]         sfr_rdata,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               pin_rst_n,
    input  logic               int_rst_req,
    input  logic               lvd_alert,
    output logic               cpu_rst,
    output logic               cpu_halt,
    output logic               periph_clk_en,
    output logic               osc_en
);
    pm_state_e        state;
    logic [REG_W-1:0] pcon;
    logic             mc_tick;
    logic             div_run;
    logic             pin_active;
    logic             ext_rst_valid;
    logic             lvd_rst;
    logic             rst_any;

    // Divider frozen in power-down unless the pin is pulling reset
    assign div_run = (state != PM_PDOWN) || pin_active;
    assign lvd_rst = lvd_alert && pcon[BIT_LVD_EN];
    assign rst_any = ext_rst_valid || int_rst_req || lvd_rst;

    pwr_mcycle_div #(.MC_CLKS(MC_CLKS)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (div_run),
        .tick  (mc_tick)
    );

    pwr_pin_qual #(.SYNC_STAGES(2), .QUAL_MC(QUAL_MC)) u_qual (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_rst_n     (pin_rst_n),
        .tick          (mc_tick),
        .pin_active    (pin_active),
        .ext_rst_valid (ext_rst_valid)
    );

    pwr_mode_fsm #(.RST_MC(RST_MC), .SFR_ADDR(SFR_ADDR)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (mc_tick),
        .rst_any       (rst_any),
        .any_irq       (|irq_req),
        .pin_active    (pin_active),
        .wr_en         (sfr_wr_en),
        .wr_addr       (sfr_addr),
        .wr_data       (sfr_wdata),
        .pcon          (pcon),
        .state         (state),
        .cpu_rst       (cpu_rst),
        .cpu_halt      (cpu_halt),
        .periph_clk_en (periph_clk_en),
        .osc_en        (osc_en)
    );

    assign sfr_rdata = pcon;

endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk #(
    parameter int unsigned NUM_IRQ = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [7:0]         sfr_rdata,
    input logic [NUM_IRQ-1:0] irq_req,
    input logic               int_rst_req,
    input logic               cpu_rst,
    input logic               cpu_halt,
    input logic               periph_clk_en,
    input logic               osc_en,
    input logic               mc_tick
);
    AST_PD_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_clk_en |-> (cpu_halt && sfr_rdata[1])); // R5

    AST_OSC_ONLY_PD: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !periph_clk_en); // R5

    AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && periph_clk_en && (|irq_req)) |=> !cpu_halt); // R4

    AST_PD_EXIT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_clk_en |=> (!periph_clk_en || cpu_rst)); // R6

    AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sfr_rdata[1] && sfr_rdata[0])); // R7

    AST_RST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst |-> (sfr_rdata == 8'h00)); // R10

    AST_RST_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst |-> (periph_clk_en && osc_en && !cpu_halt)); // R10

    AST_INT_RST: assert property (@(posedge clk) disable iff (!rst_n)
        int_rst_req |=> cpu_rst); // R10

    AST_RELEASE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_rst) |-> $past(mc_tick)); // R10

endmodule

bind pwr_mode_ctrl pwr_mode_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sfr_rdata     (sfr_rdata),
    .irq_req       (irq_req),
    .int_rst_req   (int_rst_req),
    .cpu_rst       (cpu_rst),
    .cpu_halt      (cpu_halt),
    .periph_clk_en (periph_clk_en),
    .osc_en        (osc_en),
    .mc_tick       (mc_tick)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sfr_wr_en = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rdata;
    logic [7:0] irq_req = 8'h00;
    logic       pin_rst_n = 1'b1;
    logic       int_rst_req = 1'b0;
    logic       lvd_alert = 1'b0;
    logic       cpu_rst, cpu_halt, periph_clk_en, osc_en;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pwr_mode_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .sfr_wr_en(sfr_wr_en), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .irq_req(irq_req),
        .pin_rst_n(pin_rst_n), .int_rst_req(int_rst_req), .lvd_alert(lvd_alert),
        .cpu_rst(cpu_rst), .cpu_halt(cpu_halt), .periph_clk_en(periph_clk_en),
        .osc_en(osc_en)
    );

    typedef struct packed {
        logic [7:0] wd;
        logic [7:0] rd;
        logic       halt;
        logic       pclk;
        logic       osc;
        logic [4:0] pad;
        logic [7:0] after;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 5'd0, 8'h00},
        '{8'hC4, 8'hC4, 1'b0, 1'b1, 1'b1, 5'd0, 8'hC4},
        '{8'h01, 8'h01, 1'b1, 1'b1, 1'b1, 5'd0, 8'h00},
        '{8'h81, 8'h81, 1'b1, 1'b1, 1'b1, 5'd0, 8'h80},
        '{8'h02, 8'h02, 1'b1, 1'b0, 1'b0, 5'd0, 8'h00},
        '{8'h03, 8'h02, 1'b1, 1'b0, 1'b0, 5'd0, 8'h00},
        '{8'hFF, 8'hFE, 1'b1, 1'b0, 1'b0, 5'd0, 8'h00}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        sfr_addr = a; sfr_wdata = d; sfr_wr_en = 1'b1;
        step(1);
        sfr_wr_en = 1'b0;
    endtask

    task automatic wait_release(output int cnt);
        cnt = 0;
        while (cpu_rst && cnt < 300) begin
            step(1);
            cnt++;
        end
    endtask

    task automatic pulse_int_rst(output int cnt);
        int_rst_req = 1'b1;
        step(1);
        int_rst_req = 1'b0;
        wait_release(cnt);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog all requirements actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int c;
        bit seen;
        step(3);
        rst_n = 1'b1;
        // R1: reset state and exact release
        step(1);
        chk("R1", "rdata", sfr_rdata, 8'h00);
        chk("R1", "cpu_rst", cpu_rst, 1);
        chk("R1", "enables", {periph_clk_en, osc_en}, 2'b11);
        step(34);
        chk("R1", "cpu_rst@35", cpu_rst, 1);
        step(1);
        chk("R1", "cpu_rst@36", cpu_rst, 0);

        // R2: wrong address ignored
        sfr_write(8'h86, 8'h03);
        chk("R2", "rdata wrong addr", sfr_rdata, 8'h00);
        chk("R2", "halt wrong addr", cpu_halt, 0);

        // Vector walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            sfr_write(8'h87, VECS[i].wd);
            chk("R2/R7", "rdata", sfr_rdata, VECS[i].rd);
            chk("R3/R5", "halt", cpu_halt, VECS[i].halt);
            chk("R3/R5", "periph_clk_en", periph_clk_en, VECS[i].pclk);
            chk("R3/R5", "osc_en", osc_en, VECS[i].osc);
            if (VECS[i].halt && VECS[i].pclk) begin
                irq_req = 8'h10;
                step(1);
                irq_req = 8'h00;
                chk("R4", "halt after irq", cpu_halt, 0);
                chk("R4", "rdata after irq", sfr_rdata, VECS[i].after);
            end else if (VECS[i].halt) begin
                irq_req = 8'h01;
                step(3);
                irq_req = 8'h00;
                chk("R6", "halt after irq in pd", cpu_halt, 1);
                sfr_write(8'h87, 8'h00);
                chk("R6", "rdata after write in pd", sfr_rdata, VECS[i].rd);
                chk("R6", "pclk in pd", periph_clk_en, 0);
                pulse_int_rst(c);
                chk("R10", "rdata after reset", sfr_rdata, VECS[i].after);
                chk("R10", "release window", (c >= 25 && c <= 36), 1);
            end
        end

        // R10: write during reset ignored
        int_rst_req = 1'b1;
        step(1);
        int_rst_req = 1'b0;
        chk("R10", "cpu_rst after int req", cpu_rst, 1);
        sfr_write(8'h87, 8'h01);
        chk("R2", "write during reset", sfr_rdata, 8'h00);
        wait_release(c);

        // R8: short pin pulse ignored
        sfr_write(8'h87, 8'h40);
        pin_rst_n = 1'b0;
        seen = 0;
        for (int k = 0; k < 5; k++) begin
            step(1);
            if (cpu_rst) seen = 1;
        end
        pin_rst_n = 1'b1;
        for (int k = 0; k < 30; k++) begin
            step(1);
            if (cpu_rst) seen = 1;
        end
        chk("R8", "short pulse reset", seen, 0);
        chk("R8", "short pulse rdata", sfr_rdata, 8'h40);

        // R8 R10: long pin reset
        pin_rst_n = 1'b0;
        step(40);
        chk("R8", "long pin cpu_rst", cpu_rst, 1);
        chk("R10", "long pin rdata", sfr_rdata, 8'h00);
        pin_rst_n = 1'b1;
        wait_release(c);
        chk("R10", "pin release window", (c >= 25 && c <= 39), 1);

        // R9: pin wakes oscillator from power-down
        sfr_write(8'h87, 8'h02);
        step(20);
        chk("R9", "osc off in pd", osc_en, 0);
        pin_rst_n = 1'b0;
        step(3);
        chk("R9", "osc on after pin", osc_en, 1);
        step(40);
        chk("R9", "pd pin reset", cpu_rst, 1);
        pin_rst_n = 1'b1;
        wait_release(c);
        chk("R9", "rdata after pd pin reset", sfr_rdata, 8'h00);

        // R11: low-voltage alert
        sfr_write(8'h87, 8'h00);
        lvd_alert = 1'b1;
        step(3);
        lvd_alert = 1'b0;
        chk("R11", "lvd ignored when disabled", cpu_rst, 0);
        sfr_write(8'h87, 8'h20);
        lvd_alert = 1'b1;
        step(1);
        lvd_alert = 1'b0;
        chk("R11", "lvd reset when enabled", cpu_rst, 1);
        wait_release(c);
        sfr_write(8'h87, 8'h22);
        chk("R11", "pd with lvd enable", {cpu_halt, periph_clk_en}, 2'b10);
        step(5);
        lvd_alert = 1'b1;
        step(1);
        lvd_alert = 1'b0;
        chk("R11", "lvd reset in pd", cpu_rst, 1);
        wait_release(c);
        chk("R11", "rdata after lvd", sfr_rdata, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule